// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Redirector

This block handles a software interrupt raised while the core runs in virtual-8086 mode. From the virtual-mode extension enable, the I/O privilege level and the vector's bit from the redirection bitmap, it chooses between two redirected dispatch flavours and a hand-off to protected-mode gate dispatch. The two redirected flavours share one real-mode style sequence. The sequence fetches the handler's offset and segment from the vector table at linear address 0. It pushes FLAGS, CS and IP on the stack and then returns the new CS:EIP, SP and EFLAGS.

The two redirected flavours differ in one respect. When the privilege level is below 3, the virtual interrupt flags are live. The pushed FLAGS word then carries the virtual interrupt flag in place of the real interrupt flag and reports a privilege level of 3. The core stays in virtual-8086 mode for the whole sequence.

A request is a one-cycle `start` with the operands held steady on that cycle. The memory port issues one 16-bit access per cycle. Read data must be returned on `mem_rdata` in the cycle after a read is issued.

Top module: `v86_swint_redirect`

## Requirements
- R1: With `vme`=1, `iopl` < 3 and `redir_bit`=0, `disp_method` becomes 2'b11 (virtual-flag redirect) and the redirected sequence runs.
- R2: With `vme`=1, `iopl`=3 and `redir_bit`=0, `disp_method` becomes 2'b10 (plain redirect) and the redirected sequence runs.
- R3: Any other combination gives `disp_method`=2'b01 and a one-cycle `pm_req` pulse in the cycle after `start`. There is no memory access and no `done` pulse.
- R4: A redirected sequence reads two 16-bit words. The offset is read first, at linear address vector*4, and the segment follows at vector*4+2.
- R5: At `done`, `new_cs` equals the segment read and `new_eip` equals {16'h0000, offset}.
- R6: The sequence writes three words at stack linear address SS*16 + (SP-2), (SP-4) and (SP-6), with SP taken modulo 2^16. The words are written in that order and are the FLAGS image, the old CS and `cur_ip`. `new_sp` equals SP-6 modulo 2^16.
- R7: The pushed FLAGS image is `cur_eflags[15:0]` for 2'b10. For 2'b11 it is the same word with bit 9 replaced by EFLAGS bit 19 and bits 13:12 set to 2'b11.
- R8: `new_eflags` is `cur_eflags` with bit 8 cleared. For 2'b10, bit 9 is also cleared. For 2'b11, bit 19 is also cleared.
- R9: `v86_stay` is 1 after a redirected request and 0 after a protected-mode request. `done` is a one-cycle pulse in the cycle after the last stack write, and `start` is ignored while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; operands are sampled with it |
| vme | input | 1 | Virtual-mode extensions enabled |
| iopl | input | 2 | Current I/O privilege level |
| vector | input | 8 | Interrupt vector number |
| redir_bit | input | 1 | Bit for this vector from the redirection bitmap |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Low word of current EIP (return address) |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| cur_eflags | input | 32 | Current EFLAGS |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Linear byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| disp_method | output | 2 | 01 protected mode, 10 plain redirect, 11 virtual-flag redirect |
| pm_req | output | 1 | Pulse: hand the interrupt to protected-mode dispatch |
| v86_stay | output | 1 | Core remains in virtual-8086 mode |
| new_cs | output | 16 | Handler segment |
| new_eip | output | 32 | Handler EIP, high word zero |
| new_sp | output | 16 | Stack pointer after the pushes |
| new_eflags | output | 32 | EFLAGS after dispatch |
| done | output | 1 | Pulse: redirected dispatch complete |

## Verification
A wrong decode shows up one cycle after `start`: either `pm_req` appears where the sequence should begin, or a read is issued where none belongs. A sequencer that is off by a state puts offset and segment in swapped or stale slots. It also shifts the three stack writes to the wrong addresses, and all of this is visible on the memory port within five cycles and in `new_cs`/`new_eip` at `done`. A wrong flags image is seen at the first stack write, and a wrong flag update is seen in `new_eflags` at `done`. Corners such as an SP that wraps below zero and vectors 0, 0x21 and 0xFF under both redirected flavours expose address arithmetic slips.

// File: rtl/v86r_pkg.sv
// Shared types and flag bit positions for the virtual-8086 software interrupt
// redirector. Assumes the 32-bit EFLAGS layout (TF 8, IF 9, IOPL 13:12, VIF 19).
package v86r_pkg;
    typedef enum logic [1:0] {
        DISP_NONE  = 2'b00,
        DISP_PMODE = 2'b01,
        DISP_RM5   = 2'b10,
        DISP_RM6   = 2'b11
    } disp_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_OFF, S_RD_SEG, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP
    } seq_e;

    localparam int FL_TF      = 8;
    localparam int FL_IF      = 9;
    localparam int FL_IOPL_LO = 12;
    localparam int FL_IOPL_HI = 13;
    localparam int FL_VIF     = 19;
    localparam int PUSH_WORDS = 3;
endpackage

// File: rtl/v86r_decode.sv
// Chooses the dispatch flavour for a virtual-8086 software interrupt.
// Assumes the inputs are the live values on the request cycle; purely combinational.
module v86r_decode
    import v86r_pkg::*;
#(
    parameter int IOPL_W = 2
) (
    input  logic              vme,
    input  logic [IOPL_W-1:0] iopl,
    input  logic              redir_bit,
    output disp_e             disp
);
    localparam logic [IOPL_W-1:0] IOPL_MAX = {IOPL_W{1'b1}};

    // Redirect only when extensions are on and the bitmap clears the vector.
    always_comb begin
        if (vme && !redir_bit)
            disp = (iopl == IOPL_MAX) ? DISP_RM5 : DISP_RM6;
        else
            disp = DISP_PMODE;
    end
endmodule

// File: rtl/v86r_flag_image.sv
// Builds the FLAGS word pushed on the stack and the EFLAGS value left after
// dispatch. Assumes disp holds one of the two redirect codes when used.
module v86r_flag_image
    import v86r_pkg::*;
#(
    parameter int FLAGS_W = 32,
    parameter int WORD_W  = 16
) (
    input  logic [FLAGS_W-1:0] eflags,
    input  disp_e              disp,
    output logic [WORD_W-1:0]  push_word,
    output logic [FLAGS_W-1:0] next_eflags
);
    logic virt;
    assign virt = (disp == DISP_RM6);

    // Pushed image: with virtual flags live, VIF stands in for IF and IOPL reads 3.
    always_comb begin
        push_word = eflags[WORD_W-1:0];
        if (virt) begin
            push_word[FL_IF]                 = eflags[FL_VIF];
            push_word[FL_IOPL_HI:FL_IOPL_LO] = 2'b11;
        end
    end

    // Post-dispatch flags: trap off, and the active interrupt enable off.
    always_comb begin
        next_eflags        = eflags;
        next_eflags[FL_TF] = 1'b0;
        if (virt) next_eflags[FL_VIF] = 1'b0;
        else      next_eflags[FL_IF]  = 1'b0;
    end
endmodule

// File: rtl/v86r_seq.sv
// Sequencer for redirected dispatch: latches the request, reads the vector
// table entry, pushes three words and publishes the results. Assumes memory
// read data arrives one cycle after the read is issued.
module v86r_seq
    import v86r_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 16,
    parameter int VEC_W   = 8,
    parameter int FLAGS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  disp_e              disp_in,
    input  logic [VEC_W-1:0]   vector,
    input  logic [WORD_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0]  cur_ip,
    input  logic [WORD_W-1:0]  cur_ss,
    input  logic [WORD_W-1:0]  cur_sp,
    input  logic [FLAGS_W-1:0] cur_eflags,
    input  logic [WORD_W-1:0]  push_word,
    input  logic [FLAGS_W-1:0] next_eflags,
    output logic [FLAGS_W-1:0] flags_q,
    output disp_e              disp_q,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               pm_req,
    output logic               v86_stay,
    output logic [WORD_W-1:0]  new_cs,
    output logic [2*WORD_W-1:0] new_eip,
    output logic [WORD_W-1:0]  new_sp,
    output logic [FLAGS_W-1:0] new_eflags,
    output logic               done
);
    localparam int ENTRY_SHIFT = 2;
    localparam int SEG_SHIFT   = 4;
    localparam int VPAD        = ADDR_W - VEC_W - ENTRY_SHIFT;
    localparam int SSPAD       = ADDR_W - WORD_W - SEG_SHIFT;
    localparam int SPPAD       = ADDR_W - WORD_W;
    localparam logic [WORD_W-1:0] WBYTES = WORD_W'(WORD_W / 8);

    seq_e               st;
    logic [VEC_W-1:0]   vec_q;
    logic [WORD_W-1:0]  cs_q, ip_q, ss_q, sp_q, off_q, seg_q;
    logic [ADDR_W-1:0]  vt_base;
    logic [ADDR_W-1:0]  ss_base;
    logic [ADDR_W-1:0]  push_addr [PUSH_WORDS];

    assign vt_base = {{VPAD{1'b0}}, vec_q, {ENTRY_SHIFT{1'b0}}};
    assign ss_base = {{SSPAD{1'b0}}, ss_q, {SEG_SHIFT{1'b0}}};

    // One stack address per pushed word, each a further word below SP.
    for (genvar k = 0; k < PUSH_WORDS; k++) begin : g_push
        logic [WORD_W-1:0] sp_k;
        assign sp_k         = sp_q - WORD_W'((k + 1) * (WORD_W / 8));
        assign push_addr[k] = ss_base + {{SPPAD{1'b0}}, sp_k};
    end

    // Memory port driven from the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            S_RD_OFF:  mem_addr = vt_base;
            S_RD_SEG:  mem_addr = vt_base + ADDR_W'(WBYTES);
            S_PUSH_FL: begin mem_we = 1'b1; mem_addr = push_addr[0]; mem_wdata = push_word; end
            S_PUSH_CS: begin mem_we = 1'b1; mem_addr = push_addr[1]; mem_wdata = cs_q; end
            S_PUSH_IP: begin mem_we = 1'b1; mem_addr = push_addr[2]; mem_wdata = ip_q; end
            default:   mem_req = 1'b0;
        endcase
    end

    // State register, operand latch, table capture and result publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            disp_q     <= DISP_NONE;
            vec_q      <= '0;
            cs_q       <= '0;
            ip_q       <= '0;
            ss_q       <= '0;
            sp_q       <= '0;
            flags_q    <= '0;
            off_q      <= '0;
            seg_q      <= '0;
            pm_req     <= 1'b0;
            v86_stay   <= 1'b0;
            new_cs     <= '0;
            new_eip    <= '0;
            new_sp     <= '0;
            new_eflags <= '0;
            done       <= 1'b0;
        end else begin
            pm_req <= 1'b0;
            done   <= 1'b0;
            unique case (st)
                S_IDLE: if (start) begin
                    disp_q  <= disp_in;
                    vec_q   <= vector;
                    cs_q    <= cur_cs;
                    ip_q    <= cur_ip;
                    ss_q    <= cur_ss;
                    sp_q    <= cur_sp;
                    flags_q <= cur_eflags;
                    if (disp_in == DISP_RM5 || disp_in == DISP_RM6) begin
                        v86_stay <= 1'b1;
                        st       <= S_RD_OFF;
                    end else begin
                        v86_stay <= 1'b0;
                        pm_req   <= 1'b1;
                    end
                end
                S_RD_OFF:  st <= S_RD_SEG;
                S_RD_SEG:  begin off_q <= mem_rdata; st <= S_PUSH_FL; end
                S_PUSH_FL: begin seg_q <= mem_rdata; st <= S_PUSH_CS; end
                S_PUSH_CS: st <= S_PUSH_IP;
                S_PUSH_IP: begin
                    new_cs     <= seg_q;
                    new_eip    <= {{WORD_W{1'b0}}, off_q};
                    new_sp     <= sp_q - WORD_W'(PUSH_WORDS * (WORD_W / 8));
                    new_eflags <= next_eflags;
                    done       <= 1'b1;
                    st         <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/v86_swint_redirect.sv
// Top of the virtual-8086 software interrupt redirector: decode, flag image
// and sequencer. Assumes a 16-bit word memory port with one-cycle read latency.
module v86_swint_redirect
    import v86r_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 16,
    parameter int VEC_W   = 8,
    parameter int FLAGS_W = 32,
    parameter int IOPL_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               vme,
    input  logic [IOPL_W-1:0]  iopl,
    input  logic [VEC_W-1:0]   vector,
    input  logic               redir_bit,
    input  logic [WORD_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0]  cur_ip,
    input  logic [WORD_W-1:0]  cur_ss,
    input  logic [WORD_W-1:0]  cur_sp,
    input  logic [FLAGS_W-1:0] cur_eflags,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [1:0]         disp_method,
    output logic               pm_req,
    output logic               v86_stay,
    output logic [WORD_W-1:0]  new_cs,
    output logic [2*WORD_W-1:0] new_eip,
    output logic [WORD_W-1:0]  new_sp,
    output logic [FLAGS_W-1:0] new_eflags,
    output logic               done
);
    disp_e              disp_live, disp_q;
    logic [FLAGS_W-1:0] flags_q, next_eflags;
    logic [WORD_W-1:0]  push_word;

    assign disp_method = disp_q;

    v86r_decode #(.IOPL_W(IOPL_W)) u_dec (
        .vme(vme), .iopl(iopl), .redir_bit(redir_bit), .disp(disp_live)
    );

    v86r_flag_image #(.FLAGS_W(FLAGS_W), .WORD_W(WORD_W)) u_img (
        .eflags(flags_q), .disp(disp_q),
        .push_word(push_word), .next_eflags(next_eflags)
    );

    v86r_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .VEC_W(VEC_W), .FLAGS_W(FLAGS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .disp_in(disp_live),
        .vector(vector), .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss),
        .cur_sp(cur_sp), .cur_eflags(cur_eflags), .push_word(push_word),
        .next_eflags(next_eflags), .flags_q(flags_q), .disp_q(disp_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pm_req(pm_req),
        .v86_stay(v86_stay), .new_cs(new_cs), .new_eip(new_eip),
        .new_sp(new_sp), .new_eflags(new_eflags), .done(done)
    );
endmodule

// File: rtl/v86r_chk.sv
// Protocol checker for the redirector, attached to the top by bind.
// Assumes the default 2-bit dispatch code encoding.
module v86r_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       pm_req,
    input logic       mem_req,
    input logic       addr_lsb,
    input logic [1:0] disp_method,
    input logic       v86_stay,
    input logic [15:0] eip_hi,
    input logic       tf
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R3
    pm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) pm_req |=> !pm_req);
    // R3
    pm_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n) pm_req |-> !mem_req && disp_method == 2'b01 && !v86_stay);
    // R3
    pm_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, pm_req}));
    // R5
    eip_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> eip_hi == 16'h0000);
    // R9
    stay_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> v86_stay && disp_method[1]);
    // R8
    tf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !tf);
    // R4
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !addr_lsb);
endmodule

bind v86_swint_redirect v86r_chk u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .pm_req(pm_req), .mem_req(mem_req),
    .addr_lsb(mem_addr[0]), .disp_method(disp_method), .v86_stay(v86_stay),
    .eip_hi(new_eip[31:16]), .tf(new_eflags[8])
);

// File: tb/sim_v86_swint_redirect.sv
module sim_v86_swint_redirect;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 0, vme = 0, redir_bit = 0;
    logic [1:0]  iopl = 0;
    logic [7:0]  vector = 0;
    logic [15:0] cur_cs = 0, cur_ip = 0, cur_ss = 0, cur_sp = 0;
    logic [31:0] cur_eflags = 0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 0;
    logic [1:0]  disp_method;
    logic        pm_req, v86_stay, done;
    logic [15:0] new_cs, new_sp;
    logic [31:0] new_eip, new_eflags;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [15:0] wmem [int unsigned];
    logic [31:0] wl_a [8];
    logic [15:0] wl_d [8];
    logic [31:0] rl_a [8];
    int wcnt = 0, rcnt = 0;

    v86_swint_redirect u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vme(vme), .iopl(iopl),
        .vector(vector), .redir_bit(redir_bit), .cur_cs(cur_cs), .cur_ip(cur_ip),
        .cur_ss(cur_ss), .cur_sp(cur_sp), .cur_eflags(cur_eflags),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .disp_method(disp_method),
        .pm_req(pm_req), .v86_stay(v86_stay), .new_cs(new_cs), .new_eip(new_eip),
        .new_sp(new_sp), .new_eflags(new_eflags), .done(done)
    );

    // Word memory with one-cycle read latency, logging every access.
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            wmem[mem_addr] = mem_wdata;
            if (wcnt < 8) begin wl_a[wcnt] = mem_addr; wl_d[wcnt] = mem_wdata; end
            wcnt++;
        end else if (mem_req) begin
            mem_rdata <= wmem.exists(mem_addr) ? wmem[mem_addr] : 16'hDEAD;
            if (rcnt < 8) rl_a[rcnt] = mem_addr;
            rcnt++;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_disp(logic v, logic [1:0] pl, logic b);
        if (v && !b) return (pl == 2'd3) ? 2'b10 : 2'b11;
        return 2'b01;
    endfunction

    function automatic logic [15:0] exp_push(logic m6, logic [31:0] f);
        logic [15:0] r = f[15:0];
        if (m6) begin r[9] = f[19]; r[13:12] = 2'b11; end
        return r;
    endfunction

    function automatic logic [31:0] exp_next(logic m6, logic [31:0] f);
        logic [31:0] r = f;
        r[8] = 1'b0;
        if (m6) r[19] = 1'b0; else r[9] = 1'b0;
        return r;
    endfunction

    task automatic run_one(logic v, logic [1:0] pl, logic [7:0] vec, logic b,
                           logic [15:0] cs, logic [15:0] ip, logic [15:0] ss,
                           logic [15:0] sp, logic [31:0] fl);
        logic [1:0]  ed = exp_disp(v, pl, b);
        logic [15:0] off = 16'($urandom), seg = 16'($urandom);
        logic [31:0] tb_base = {8'h0, vec, 2'b00};
        logic [31:0] sbase = {12'h0, ss, 4'h0};
        bit saw_done = 0, saw_pm = 0;
        wmem[tb_base] = off;
        wmem[tb_base + 2] = seg;
        @(negedge clk);
        vme = v; iopl = pl; vector = vec; redir_bit = b;
        cur_cs = cs; cur_ip = ip; cur_ss = ss; cur_sp = sp; cur_eflags = fl;
        wcnt = 0; rcnt = 0; start = 1;
        @(negedge clk);
        start = 0;
        if (ed == 2'b01) chk("R3", "pm_req pulse", 32'(pm_req), 1);
        for (int i = 0; i < 10; i++) begin
            if (done) saw_done = 1;
            if (pm_req && i > 0) saw_pm = 1;
            if (!saw_done) @(negedge clk);
        end
        if (ed == 2'b01) begin
            chk("R3", "method", 32'(disp_method), 32'(ed));
            chk("R3", "no done", 32'(saw_done), 0);
            chk("R3", "second pm pulse", 32'(saw_pm), 0);
            chk("R3", "mem accesses", 32'(wcnt + rcnt), 0);
            chk("R9", "stay after pm", 32'(v86_stay), 0);
        end else begin
            chk(ed == 2'b11 ? "R1" : "R2", "method", 32'(disp_method), 32'(ed));
            chk("R9", "done seen", 32'(saw_done), 1);
            chk("R9", "stay", 32'(v86_stay), 1);
            chk("R4", "read count", 32'(rcnt), 2);
            chk("R4", "offset addr", rl_a[0], tb_base);
            chk("R4", "segment addr", rl_a[1], tb_base + 2);
            chk("R5", "new_cs", 32'(new_cs), 32'(seg));
            chk("R5", "new_eip", new_eip, {16'h0, off});
            chk("R6", "write count", 32'(wcnt), 3);
            chk("R6", "flags addr", wl_a[0], sbase + {16'h0, 16'(sp - 16'd2)});
            chk("R6", "cs addr", wl_a[1], sbase + {16'h0, 16'(sp - 16'd4)});
            chk("R6", "ip addr", wl_a[2], sbase + {16'h0, 16'(sp - 16'd6)});
            chk("R7", "flags image", 32'(wl_d[0]), 32'(exp_push(ed == 2'b11, fl)));
            chk("R6", "old cs", 32'(wl_d[1]), 32'(cs));
            chk("R6", "old ip", 32'(wl_d[2]), 32'(ip));
            chk("R6", "new_sp", 32'(new_sp), 32'(16'(sp - 16'd6)));
            chk("R8", "new_eflags", new_eflags, exp_next(ed == 2'b11, fl));
            @(negedge clk);
            chk("R9", "done one cycle", 32'(done), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R9", "reset done", 32'(done), 0);
        chk("R3", "reset pm_req", 32'(pm_req), 0);
        chk("R9", "reset stay", 32'(v86_stay), 0);
        rst_n = 1;
        // Directed: vectors 0, 0x21, 0xFF under both redirected flavours.
        foreach (wl_a[i]) begin wl_a[i] = 0; wl_d[i] = 0; rl_a[i] = 0; end
        run_one(1, 2'd3, 8'h00, 0, 16'h1234, 16'h5678, 16'h3000, 16'h0100, 32'h0008_0302);
        run_one(1, 2'd0, 8'h00, 0, 16'h1234, 16'h5678, 16'h3000, 16'h0100, 32'h0008_0302);
        run_one(1, 2'd3, 8'h21, 0, 16'hABCD, 16'h0010, 16'h4000, 16'hFFFE, 32'h0000_0300);
        run_one(1, 2'd1, 8'h21, 0, 16'hABCD, 16'h0010, 16'h4000, 16'hFFFE, 32'h0018_1100);
        run_one(1, 2'd3, 8'hFF, 0, 16'h0F0F, 16'hF0F0, 16'h5000, 16'h8000, 32'h0000_F3FF);
        run_one(1, 2'd2, 8'hFF, 0, 16'h0F0F, 16'hF0F0, 16'h5000, 16'h8000, 32'h0008_0200);
        // Corner: SP wraps below zero (R6).
        run_one(1, 2'd0, 8'h10, 0, 16'h2222, 16'h3333, 16'h2000, 16'h0004, 32'h0008_0100);
        // Protected-mode hand-off cases (R3).
        run_one(0, 2'd3, 8'h21, 0, 16'h1, 16'h2, 16'h3000, 16'h0100, 32'h0);
        run_one(1, 2'd3, 8'h21, 1, 16'h1, 16'h2, 16'h3000, 16'h0100, 32'h0);
        run_one(1, 2'd0, 8'h05, 1, 16'h1, 16'h2, 16'h3000, 16'h0100, 32'h0);
        // Constrained random trials.
        for (int t = 0; t < 60; t++) begin
            logic v = ($urandom % 5) != 0;
            logic b = ($urandom % 4) == 0;
            run_one(v, 2'($urandom), 8'($urandom), b, 16'($urandom), 16'($urandom),
                    16'h1000 + 16'($urandom % 16'h8000), 16'($urandom) & 16'hFFFE,
                    $urandom);
        end
        // Start ignored while busy (R9): second start mid-sequence leaves writes at three.
        @(negedge clk);
        vme = 1; iopl = 3; redir_bit = 0; vector = 8'h21; cur_sp = 16'h0200; cur_ss = 16'h3000;
        wcnt = 0; start = 1;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (8) @(negedge clk);
        chk("R9", "start ignored while busy", 32'(wcnt), 3);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule